// File: doc/BRIEF.md
# Nibble-Serial Arithmetic Logic Unit

This block carries out 8-bit arithmetic and logic operations on a single 4-bit datapath slice. Each byte operation takes two slice passes: the low nibble goes first and the high nibble second, and a registered carry links the two passes. A 16-bit add works the same way over four chained passes. The block has no wide adder. It also provides a decimal-adjust operation that repairs a packed-BCD byte after an add or a subtract. The decision logic for that operation is a pair of fixed-constant comparators, and the correction they produce is sent through the same slice.

The surrounding control logic presents two operands, an operation code and the current flag vector, then pulses a start strobe. The unit latches those inputs and runs its passes. It then raises a done pulse for one cycle, with the result and the new flags held on its outputs until the next operation completes. While the unit is busy, any further start strobe is ignored.

Top module: `nsalu`

## Requirements
- R1: After reset, busy_o, done_o, res_o and flags_o are all zero.
- R2: Suppose start_i is sampled high at clock edge k while the unit is idle. A byte operation then raises done_o after edge k+2 and an ADD16 operation raises it after edge k+4. In both cases done_o stays high for exactly one cycle, and busy_o is high from edge k until the final pass.
- R3: ADD (code 0) and ADC (code 1) compute x_i[7:0] + y_i[7:0], plus flags_i[0] for ADC. They place the sum in res_o[7:0], with res_o[15:8] = 0. The flag vector is {Z,N,H,C} in bits 3..0. Z is set when the byte result is zero, N is 0, H is the carry out of bit 3 and C is the carry out of bit 7.
- R4: SUB (code 2) and SBC (code 3) compute x_i[7:0] - y_i[7:0], minus flags_i[0] for SBC. They set N=1, H to the borrow out of bit 3, C to the borrow out of bit 7, and Z when the result is zero.
- R5: CP (code 7) sets the flags exactly as SUB does but returns x_i[7:0] unchanged as the result.
- R6: AND (code 4) gives flags Z,0,1,0. XOR (code 5) and OR (code 6) give flags Z,0,0,0.
- R7: PASS (code 8) returns y_i[7:0] and copies flags_i to flags_o unchanged. Codes 11 to 15 behave like PASS.
- R8: DAA (code 9) with flags_i N=0 works on x_i[7:0]. It adds 0x06 if the low nibble exceeds 9 or flags_i H is set. It adds 0x60, and sets C, if the byte exceeds 0x99 or flags_i C is set. Otherwise C is 0.
- R9: DAA with flags_i N=1 subtracts 0x06 when H is set and 0x60 when C is set, and keeps C and N. For both DAA cases H is 0 and Z reflects the result.
- R10: ADD16 (code 10) returns x_i + y_i on 16 bits. It keeps flags_i Z and clears N. It sets H from the carry out of bit 11 and C from the carry out of bit 15.
- R11: A start strobe while busy_o is high has no effect. The running operation finishes with its own result, and no extra done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, accepted only while idle |
| op_i | input | 4 | Operation code |
| x_i | input | 16 | First operand (low byte for byte operations) |
| y_i | input | 16 | Second operand (low byte for byte operations) |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| busy_o | output | 1 | High while nibble passes are in progress |
| done_o | output | 1 | One-cycle pulse when the last pass completes |
| res_o | output | 16 | Result, held until the next completion |
| flags_o | output | 4 | Result flags {Z,N,H,C}, held |

## Verification
Every byte operation, including one reserved code, is run against all 256 first operands and a set of second operands. That set holds zero, all-ones, nibble-boundary values and BCD values, and the incoming flags vary with the operands. This separates a wrong carry hand-off between nibbles, which shows up at 0x0F/0x10 crossings, from a wrong H or C source. Decimal adjust is swept over every byte with every incoming flag combination, so the comparator thresholds 9 and 0x99 and the add and subtract paths are each exercised. The 16-bit add uses pseudo-random pairs plus carry-chain edge cases at bits 11 and 15, and a start strobe issued during a running operation confirms that the unit rejects it.

// File: rtl/nsalu_pkg.sv
package nsalu_pkg;
  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_ADC   = 4'd1;
  localparam logic [3:0] OP_SUB   = 4'd2;
  localparam logic [3:0] OP_SBC   = 4'd3;
  localparam logic [3:0] OP_AND   = 4'd4;
  localparam logic [3:0] OP_XOR   = 4'd5;
  localparam logic [3:0] OP_OR    = 4'd6;
  localparam logic [3:0] OP_CP    = 4'd7;
  localparam logic [3:0] OP_PASS  = 4'd8;
  localparam logic [3:0] OP_DAA   = 4'd9;
  localparam logic [3:0] OP_ADD16 = 4'd10;

  localparam int FL_Z = 3;
  localparam int FL_N = 2;
  localparam int FL_H = 1;
  localparam int FL_C = 0;

  typedef enum logic [2:0] {
    SL_ADD, SL_SUB, SL_AND, SL_XOR, SL_OR, SL_PASSB
  } slice_fn_e;
endpackage

// File: rtl/nsalu_rst_sync.sv
module nsalu_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/nsalu_slice.sv
module nsalu_slice
  import nsalu_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  slice_fn_e        fn,
  input  logic [NIB_W-1:0] a,
  input  logic [NIB_W-1:0] b,
  input  logic             cin,
  output logic [NIB_W-1:0] r,
  output logic             cout
);
  logic             inv;
  logic [NIB_W:0]   sum;

  // Subtract as a + ~b + ~borrow; the outgoing carry is inverted back to a borrow.
  always_comb begin
    inv  = (fn == SL_SUB);
    sum  = {1'b0, a} + {1'b0, b ^ {NIB_W{inv}}} + {{NIB_W{1'b0}}, cin ^ inv};
    r    = b;
    cout = 1'b0;
    unique case (fn)
      SL_ADD, SL_SUB: begin
        r    = sum[NIB_W-1:0];
        cout = sum[NIB_W] ^ inv;
      end
      SL_AND:   r = a & b;
      SL_XOR:   r = a ^ b;
      SL_OR:    r = a | b;
      default:  r = b;
    endcase
  end
endmodule

// File: rtl/nsalu_daa.sv
module nsalu_daa #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] val,
  input  logic              n_in,
  input  logic              h_in,
  input  logic              c_in,
  output logic [BYTE_W-1:0] corr,
  output logic              c_out
);
  localparam int HALF = BYTE_W / 2;
  localparam logic [HALF-1:0]   NIB_LIMIT  = HALF'(9);
  localparam logic [BYTE_W-1:0] BYTE_LIMIT = BYTE_W'(8'h99);
  localparam logic [HALF-1:0]   SIX        = HALF'(6);

  logic lo_over, hi_over, fix_lo, fix_hi;

  always_comb begin
    lo_over = (val[HALF-1:0] > NIB_LIMIT);
    hi_over = (val > BYTE_LIMIT);
    fix_lo  = n_in ? h_in : (h_in | lo_over);
    fix_hi  = n_in ? c_in : (c_in | hi_over);
    corr    = {(fix_hi ? SIX : '0), (fix_lo ? SIX : '0)};
    c_out   = fix_hi;
  end
endmodule

// File: rtl/nsalu.sv
module nsalu
  import nsalu_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int BYTE_W = 8,
  parameter int WIDE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [3:0]        op_i,
  input  logic [WIDE_W-1:0] x_i,
  input  logic [WIDE_W-1:0] y_i,
  input  logic [3:0]        flags_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WIDE_W-1:0] res_o,
  output logic [3:0]        flags_o
);
  localparam int NB = BYTE_W / NIB_W;
  localparam int NW = WIDE_W / NIB_W;
  localparam int PW = $clog2(NW);
  localparam logic [PW-1:0] LAST_B = PW'(NB - 1);
  localparam logic [PW-1:0] LAST_W = PW'(NW - 1);
  localparam logic [PW-1:0] HPAS_B = PW'(NB - 2);
  localparam logic [PW-1:0] HPAS_W = PW'(NW - 2);

  logic srst_n;

  logic              busy_q, busy_d, done_q, done_d, cry_q, cry_d, hc_q, hc_d;
  logic [PW-1:0]     pass_q, pass_d;
  logic [3:0]        op_q, op_d, fin_q, fin_d, flg_q, flg_d;
  logic [WIDE_W-1:0] x_q, x_d, y_q, y_d, acc_q, acc_d, res_q, res_d;

  logic              wide, last, sub_op, init_c, s_cin, s_cout, daa_c;
  logic [PW-1:0]     hpass;
  slice_fn_e         fn;
  logic [NIB_W-1:0]  a_nib, b_nib, s_r;
  logic [BYTE_W-1:0] daa_corr, r8;
  logic [WIDE_W-1:0] b_src;

  nsalu_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  nsalu_daa #(.BYTE_W(BYTE_W)) u_daa (
    .val(x_q[BYTE_W-1:0]), .n_in(fin_q[FL_N]), .h_in(fin_q[FL_H]),
    .c_in(fin_q[FL_C]), .corr(daa_corr), .c_out(daa_c)
  );

  nsalu_slice #(.NIB_W(NIB_W)) u_slice (
    .fn(fn), .a(a_nib), .b(b_nib), .cin(s_cin), .r(s_r), .cout(s_cout)
  );

  // Operand steering for the current pass
  always_comb begin
    wide   = (op_q == OP_ADD16);
    last   = (pass_q == (wide ? LAST_W : LAST_B));
    hpass  = wide ? HPAS_W : HPAS_B;
    sub_op = (op_q == OP_SUB) || (op_q == OP_SBC) || (op_q == OP_CP);
    init_c = ((op_q == OP_ADC) || (op_q == OP_SBC)) ? fin_q[FL_C] : 1'b0;
    s_cin  = (pass_q == '0) ? init_c : cry_q;
    b_src  = (op_q == OP_DAA) ? {{(WIDE_W-BYTE_W){1'b0}}, daa_corr} : y_q;
    a_nib  = x_q[pass_q*NIB_W +: NIB_W];
    b_nib  = b_src[pass_q*NIB_W +: NIB_W];
    case (op_q)
      OP_ADD, OP_ADC, OP_ADD16: fn = SL_ADD;
      OP_SUB, OP_SBC, OP_CP:    fn = SL_SUB;
      OP_AND:                   fn = SL_AND;
      OP_XOR:                   fn = SL_XOR;
      OP_OR:                    fn = SL_OR;
      OP_DAA:                   fn = fin_q[FL_N] ? SL_SUB : SL_ADD;
      default:                  fn = SL_PASSB;
    endcase
  end

  // Next-state logic
  always_comb begin
    busy_d = busy_q;  done_d = 1'b0;  cry_d = cry_q;  hc_d = hc_q;
    pass_d = pass_q;  op_d = op_q;    fin_d = fin_q;  flg_d = flg_q;
    x_d = x_q;  y_d = y_q;  acc_d = acc_q;  res_d = res_q;
    r8  = '0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;  pass_d = '0;  acc_d = '0;
        op_d = op_i;  x_d = x_i;  y_d = y_i;  fin_d = flags_i;
      end
    end else begin
      acc_d[pass_q*NIB_W +: NIB_W] = s_r;
      cry_d  = s_cout;
      pass_d = pass_q + 1'b1;
      if (pass_q == hpass) hc_d = s_cout;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        r8     = acc_d[BYTE_W-1:0];
        res_d  = {{(WIDE_W-BYTE_W){1'b0}}, r8};
        case (op_q)
          OP_ADD, OP_ADC, OP_SUB, OP_SBC:
            flg_d = {r8 == '0, sub_op, hc_q, s_cout};
          OP_CP: begin
            res_d = {{(WIDE_W-BYTE_W){1'b0}}, x_q[BYTE_W-1:0]};
            flg_d = {r8 == '0, 1'b1, hc_q, s_cout};
          end
          OP_AND:        flg_d = {r8 == '0, 3'b010};
          OP_XOR, OP_OR: flg_d = {r8 == '0, 3'b000};
          OP_DAA:
            flg_d = {r8 == '0, fin_q[FL_N], 1'b0,
                     fin_q[FL_N] ? fin_q[FL_C] : daa_c};
          OP_ADD16: begin
            res_d = acc_d;
            flg_d = {fin_q[FL_Z], 1'b0, hc_q, s_cout};
          end
          default: flg_d = fin_q;
        endcase
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      busy_q <= 1'b0;  done_q <= 1'b0;  cry_q <= 1'b0;  hc_q <= 1'b0;
      pass_q <= '0;    op_q <= '0;      fin_q <= '0;    flg_q <= '0;
      x_q <= '0;  y_q <= '0;  acc_q <= '0;  res_q <= '0;
    end else begin
      busy_q <= busy_d;  done_q <= done_d;  cry_q <= cry_d;  hc_q <= hc_d;
      pass_q <= pass_d;  op_q <= op_d;      fin_q <= fin_d;  flg_q <= flg_d;
      x_q <= x_d;  y_q <= y_d;  acc_q <= acc_d;  res_q <= res_d;
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign res_o   = res_q;
  assign flags_o = flg_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!srst_n)
    done_q |=> !done_q);  // R2
  AST_LOW_NIBBLE_FIRST: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(busy_q) |-> (pass_q == '0));  // R2
  AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (!srst_n)
    busy_q |=> ($stable(op_q) && $stable(x_q) && $stable(y_q)));  // R11
  AST_AND_SETS_H: assert property (@(posedge clk) disable iff (!srst_n)
    (done_q && op_q == OP_AND) |-> (flg_q[FL_H] && !flg_q[FL_C]));  // R6
  AST_WIDE_FLAGS: assert property (@(posedge clk) disable iff (!srst_n)
    (done_q && op_q == OP_ADD16) |-> (!flg_q[FL_N] && flg_q[FL_Z] == fin_q[FL_Z]));  // R10
  AST_DAA_KEEPS_C: assert property (@(posedge clk) disable iff (!srst_n)
    (done_q && op_q == OP_DAA && !fin_q[FL_N] && fin_q[FL_C]) |-> flg_q[FL_C]);  // R8
endmodule

// File: tb/nsalu_test.sv
module nsalu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [15:0] x_i = '0, y_i = '0;
  logic [3:0]  flags_i = '0;
  logic        busy_o, done_o;
  logic [15:0] res_o;
  logic [3:0]  flags_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nsalu uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .x_i(x_i),
    .y_i(y_i), .flags_i(flags_i), .busy_o(busy_o), .done_o(done_o),
    .res_o(res_o), .flags_o(flags_o)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:       return "R3";
      4'd2, 4'd3:       return "R4";
      4'd7:             return "R5";
      4'd4, 4'd5, 4'd6: return "R6";
      4'd9:             return "R8/R9";
      4'd10:            return "R10";
      default:          return "R7";
    endcase
  endfunction

  // Returns {result[15:0], flags {Z,N,H,C}}
  function automatic logic [19:0] model(input logic [3:0] op, input logic [15:0] x,
                                        input logic [15:0] y, input logic [3:0] f);
    int s, hs, xb, yb, ci;
    logic [7:0] r;
    xb = int'(x[7:0]);  yb = int'(y[7:0]);  ci = int'(f[0]);
    case (op)
      4'd0, 4'd1: begin
        if (op == 4'd0) ci = 0;
        s = xb + yb + ci;  hs = (xb % 16) + (yb % 16) + ci;  r = 8'(s);
        return {8'h00, r, r == 8'h00, 1'b0, hs > 15, s > 255};
      end
      4'd2, 4'd3, 4'd7: begin
        if (op != 4'd3) ci = 0;
        s = xb - yb - ci;  hs = (xb % 16) - (yb % 16) - ci;  r = 8'(s);
        return {8'h00, (op == 4'd7) ? x[7:0] : r, r == 8'h00, 1'b1, hs < 0, s < 0};
      end
      4'd4: begin r = x[7:0] & y[7:0]; return {8'h00, r, r == 8'h00, 3'b010}; end
      4'd5: begin r = x[7:0] ^ y[7:0]; return {8'h00, r, r == 8'h00, 3'b000}; end
      4'd6: begin r = x[7:0] | y[7:0]; return {8'h00, r, r == 8'h00, 3'b000}; end
      4'd9: begin
        s = xb;
        if (!f[2]) begin
          if (f[0] || xb > 153) s = s + 96;
          if (f[1] || (xb % 16) > 9) s = s + 6;
          r = 8'(s);
          return {8'h00, r, r == 8'h00, 1'b0, 1'b0, f[0] || xb > 153};
        end else begin
          if (f[0]) s = s - 96;
          if (f[1]) s = s - 6;
          r = 8'(s);
          return {8'h00, r, r == 8'h00, 1'b1, 1'b0, f[0]};
        end
      end
      4'd10: begin
        s  = int'(x) + int'(y);
        hs = int'(x[11:0]) + int'(y[11:0]);
        return {16'(s), f[3], 1'b0, hs > 4095, s > 65535};
      end
      default: return {8'h00, y[7:0], f};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Issues one operation; returns at the negedge where done is seen.
  task automatic run_op(input logic [3:0] op, input logic [15:0] x, input logic [15:0] y,
                        input logic [3:0] f);
    logic [19:0] exp;
    int cyc, want;
    exp  = model(op, x, y, f);
    want = (op == 4'd10) ? 4 : 2;
    op_i = op;  x_i = x;  y_i = y;  flags_i = f;  start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 12) begin
      @(negedge clk);
      cyc++;
    end
    // R2 timing is folded into every operation check
    check(res_o == exp[19:4] && flags_o == exp[3:0] && cyc == want, req_of(op),
          $sformatf("op=%0d x=%h y=%h f=%b {res,flags,cyc}", op, x, y, f),
          {8'h00, res_o, flags_o, 4'(cyc)}, {8'h00, exp, 4'(want)});
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] bset [6];
    logic [15:0] lfsr;
    logic [3:0]  oplist [10];
    bset   = '{16'h00, 16'h0F, 16'h10, 16'h99, 16'hFF, 16'h5A};
    oplist = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd13};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy_o && !done_o, "R1", "busy/done after reset", {30'd0, busy_o, done_o}, 32'd0);
    check(res_o == 16'h0 && flags_o == 4'h0, "R1", "res/flags after reset",
          {12'd0, res_o, flags_o}, 32'd0);

    // R2: busy visible during a byte op, done a single cycle
    op_i = 4'd0;  x_i = 16'h12;  y_i = 16'h34;  flags_i = '0;  start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && !done_o, "R2", "busy after start", {30'd0, busy_o, done_o}, 32'd2);
    @(negedge clk);
    @(negedge clk);
    check(done_o && !busy_o, "R2", "done after second pass", {30'd0, busy_o, done_o}, 32'd1);
    @(negedge clk);
    check(!done_o, "R2", "done lasts one cycle", {31'd0, done_o}, 32'd0);

    // Byte operations: all first operands against a boundary set
    for (int oi = 0; oi < 10; oi++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 6; bi++)
          run_op(oplist[oi], 16'(a), bset[bi], 4'(a) ^ bset[bi][7:4]);

    // R8 and R9: decimal adjust over every byte and flag combination
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 16; f++)
        run_op(4'd9, 16'(a), 16'h0000, 4'(f));

    // R10: wide add, carry-chain corners then pseudo-random pairs
    run_op(4'd10, 16'hFFFF, 16'h0001, 4'b0000);
    run_op(4'd10, 16'h0FFF, 16'h0001, 4'b1111);
    run_op(4'd10, 16'h0000, 16'h0000, 4'b1010);
    run_op(4'd10, 16'h8000, 16'h8000, 4'b0101);
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      logic [15:0] p;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_op(4'd10, p, lfsr, p[3:0]);
    end

    // R11: start while busy is ignored
    op_i = 4'd0;  x_i = 16'h01;  y_i = 16'h01;  flags_i = '0;  start_i = 1'b1;
    @(negedge clk);
    op_i = 4'd2;  x_i = 16'h09;  y_i = 16'h01;  flags_i = 4'b0001;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    check(done_o && res_o == 16'h0002 && flags_o == 4'b0000, "R11", "first op result kept",
          {11'd0, done_o, res_o, flags_o}, {11'd0, 1'b1, 16'h0002, 4'b0000});
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!done_o && !busy_o && res_o == 16'h0002, "R11", "no extra operation",
            {14'd0, done_o, busy_o, res_o}, {16'd0, 16'h0002});
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule